// File: doc/BRIEF.md
# Selectable 32-bit Byte Order Unit

This unit sits in the read data path of a DMA engine. It reorders the four bytes of every 32-bit word that passes through it. A beat on the stream may carry several 32-bit words side by side, and each word is treated on its own. Words arrive and leave on a valid/ready stream.

A 2-bit order code chooses one of four byte orderings:
- keep the word as it is;
- reverse all four bytes;
- exchange the two 16-bit halves;
- swap the two bytes inside each half.

The code comes from bits 3:2 of the DMA control word. The unit captures it on the transfer's start pulse and holds it for the rest of the transfer, so a later change on the code input has no effect until the next start.

A parameter selects the build. The registered build has one output register stage with one cycle of latency and full throughput. The combinational build has no latency and passes ready straight through.

Top module: `byte_order_swapper`

## Requirements
- R1: With order code 0, every output byte equals the input byte in the same position.
- R2: With order code 1, the byte order of each word is reversed: input bytes B3 B2 B1 B0 (B3 in bits 31:24) leave as B0 B1 B2 B3.
- R3: With order code 2, the two 16-bit halves of each word are exchanged: B3 B2 B1 B0 leaves as B1 B0 B3 B2.
- R4: With order code 3, the bytes inside each 16-bit half are swapped and the halves stay in place: B3 B2 B1 B0 leaves as B2 B3 B0 B1.
- R5: A word accepted in the cycle where `xfer_start` is high uses `cfg_order`. Any other accepted word uses the code captured at the most recent start. Changes on `cfg_order` without a start have no effect on the output.
- R6: After reset, `out_valid` is low, `in_ready` is high, and the held order code is 0 (pass-through) until the first start.
- R7: In the registered build, a word accepted at a clock edge is presented on `out_valid`/`out_data` right after that edge. `out_valid` falls after an edge where the held word is taken and no new word is accepted.
- R8: In the registered build, `in_ready` is high whenever `out_ready` is high or no word is held, so one word per cycle flows under no backpressure.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data` holds its value at the next edge.
- R10: Each 32-bit word of a beat is reordered independently with the same code: word k of the output depends only on word k of the input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | Transfer start pulse; captures `cfg_order` |
| cfg_order | input | 2 | Byte order code (control word bits 3:2) |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with `in_valid` |
| in_data | input | WORDS*32 | Input beat, word k in bits 32k+31:32k |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | WORDS*32 | Reordered output beat |

## Verification
The bench targets four kinds of error.

**Mapping errors.** It uses byte patterns whose bytes are all distinct. Under these patterns, mixing up the half swap with the pair swap, or leaving a code out of the mapping, puts visibly wrong bytes on the output. Two lanes carry different data, so a lane cross-wire shows up as well.

**Mode capture.** It changes `cfg_order` in the middle of a transfer without a start, and it sends a word in the same cycle as the start. A design that reads the live code, or that captures it one cycle late, reorders those words wrongly.

**Backpressure.** It holds `out_ready` low over several cycles and also toggles it at random. A stage that drops, duplicates, or overwrites a held word, or that raises `in_ready` while stalled, breaks the cycle-by-cycle queue model.

**Reset.** It sends a word before any start. This catches a mode register that resets to a code other than 0.

// File: rtl/bo_pkg.sv
package bo_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = BYTE_W * WORD_BYTES;
  localparam int SEL_W      = $clog2(WORD_BYTES);

  typedef enum logic [1:0] {
    ORD_KEEP    = 2'd0,
    ORD_REVERSE = 2'd1,
    ORD_HALVES  = 2'd2,
    ORD_PAIRS   = 2'd3
  } order_e;

  // Every ordering is an XOR of the destination byte index with a mask.
  function automatic logic [SEL_W-1:0] order_mask(input order_e m);
    case (m)
      ORD_KEEP:    order_mask = 2'b00;
      ORD_REVERSE: order_mask = 2'b11;
      ORD_HALVES:  order_mask = 2'b10;
      default:     order_mask = 2'b01;
    endcase
  endfunction
endpackage

// File: rtl/bo_mode_hold.sv
module bo_mode_hold
  import bo_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       xfer_start,
  input  logic [1:0] cfg_order,
  output order_e     eff_order
);
  order_e held_q;

  always_ff @(posedge clk) begin
    if (rst)             held_q <= ORD_KEEP;
    else if (xfer_start) held_q <= order_e'(cfg_order);
  end

  // The start cycle itself already uses the incoming code.
  assign eff_order = xfer_start ? order_e'(cfg_order) : held_q;

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    !xfer_start |=> $stable(held_q)); // R5
  AST_MODE_TAKEN: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> held_q == order_e'($past(cfg_order))); // R5
endmodule

// File: rtl/bo_swap_lane.sv
module bo_swap_lane
  import bo_pkg::*;
(
  input  order_e              order,
  input  logic [WORD_W-1:0]   word_in,
  output logic [WORD_W-1:0]   word_out
);
  logic [SEL_W-1:0] mask;
  assign mask = order_mask(order);

  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_byte
    logic [SEL_W-1:0] src;
    assign src = SEL_W'(k) ^ mask;
    assign word_out[k*BYTE_W +: BYTE_W] = word_in[src*BYTE_W +: BYTE_W];
  end

  // A byte permutation never changes the number of set bits.
  always_comb begin
    if (!$isunknown(word_in))
      AST_BITS_KEPT: assert ($countones(word_in) == $countones(word_out)); // R1
  end
endmodule

// File: rtl/bo_out_stage.sv
module bo_out_stage #(
  parameter bit REGISTERED = 1'b1,
  parameter int DATA_W     = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  if (REGISTERED) begin : g_reg
    logic              vld_q;
    logic [DATA_W-1:0] dat_q;

    assign in_ready = !vld_q || out_ready;

    always_ff @(posedge clk) begin
      if (rst)           vld_q <= 1'b0;
      else if (in_ready) vld_q <= in_valid;
    end

    always_ff @(posedge clk) begin
      if (in_ready && in_valid) dat_q <= in_data;
    end

    assign out_valid = vld_q;
    assign out_data  = dat_q;

    AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready |=> out_valid); // R7
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_data)); // R9
    AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |-> !in_ready); // R9
    AST_FLOW: assert property (@(posedge clk) disable iff (rst)
      out_ready |-> in_ready); // R8
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end
endmodule

// File: rtl/byte_order_swapper.sv
module byte_order_swapper
  import bo_pkg::*;
#(
  parameter int WORDS      = 2,
  parameter bit REGISTERED = 1'b1,
  localparam int DATA_W    = WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_start,
  input  logic [1:0]        cfg_order,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  order_e            cur_order;
  logic [DATA_W-1:0] swapped;

  bo_mode_hold u_mode (
    .clk        (clk),
    .rst        (rst),
    .xfer_start (xfer_start),
    .cfg_order  (cfg_order),
    .eff_order  (cur_order)
  );

  for (genvar w = 0; w < WORDS; w++) begin : g_lane
    bo_swap_lane u_lane (
      .order    (cur_order),
      .word_in  (in_data[w*WORD_W +: WORD_W]),
      .word_out (swapped[w*WORD_W +: WORD_W])
    );
  end

  bo_out_stage #(
    .REGISTERED (REGISTERED),
    .DATA_W     (DATA_W)
  ) u_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (swapped),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) && REGISTERED |-> !out_valid); // R6
endmodule

// File: tb/byte_order_swapper_bench.sv
module byte_order_swapper_bench;
  localparam int WORDS  = 2;
  localparam int DATA_W = WORDS * 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              xfer_start = 1'b0;
  logic [1:0]        cfg_order = 2'd0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [DATA_W-1:0] out_data;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  byte_order_swapper #(.WORDS(WORDS), .REGISTERED(1'b1)) u_byte_order_swapper (
    .clk(clk), .rst(rst), .xfer_start(xfer_start), .cfg_order(cfg_order),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // Reference model state
  logic [DATA_W-1:0] exp_q[$];
  int                mode_q[$];
  int                model_mode = 0;
  logic              prev_stall = 1'b0;
  logic [DATA_W-1:0] prev_data  = '0;

  function automatic logic [31:0] ref_word(input int m, input logic [31:0] w);
    logic [7:0] b0, b1, b2, b3;
    b0 = w[7:0]; b1 = w[15:8]; b2 = w[23:16]; b3 = w[31:24];
    case (m)
      0: return w;                    // R1
      1: return {b0, b1, b2, b3};     // R2
      2: return {w[15:0], w[31:16]};  // R3
      default: return {b2, b3, b0, b1}; // R4
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] ref_beat(input int m, input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    for (int k = 0; k < WORDS; k++) r[k*32 +: 32] = ref_word(m, d[k*32 +: 32]); // R10
    return r;
  endfunction

  task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One cycle: drive after the falling edge, check, then update the model at the rising edge.
  task automatic step(input logic st, input logic [1:0] md, input logic iv,
                      input logic [DATA_W-1:0] d, input logic ordy);
    int  eff;
    logic acc, take;
    @(negedge clk);
    xfer_start = st; cfg_order = md; in_valid = iv; in_data = d; out_ready = ordy;
    #1;
    eff = st ? int'(md) : model_mode;
    check("R7 out_valid", DATA_W'(out_valid), DATA_W'(exp_q.size() != 0));
    check("R8/R9 in_ready", DATA_W'(in_ready), DATA_W'(exp_q.size() == 0 || ordy));
    if (prev_stall) check("R9 held data", out_data, prev_data);
    if (exp_q.size() != 0) begin
      string t;
      case (mode_q[0])
        0: t = "R1/R5/R10 data";
        1: t = "R2/R5/R10 data";
        2: t = "R3/R5/R10 data";
        default: t = "R4/R5/R10 data";
      endcase
      check(t, out_data, exp_q[0]);
    end
    acc  = iv && (exp_q.size() == 0 || ordy);
    take = (exp_q.size() != 0) && ordy;
    prev_stall = (exp_q.size() != 0) && !ordy;
    prev_data  = out_data;
    @(posedge clk);
    if (take) begin void'(exp_q.pop_front()); void'(mode_q.pop_front()); end
    if (acc) begin exp_q.push_back(ref_beat(eff, d)); mode_q.push_back(eff); end
    if (st) model_mode = int'(md);
  endtask

  function automatic logic [DATA_W-1:0] rnd_beat();
    logic [DATA_W-1:0] r;
    for (int k = 0; k < WORDS; k++) r[k*32 +: 32] = $urandom();
    return r;
  endfunction

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    check("R6 out_valid after reset", DATA_W'(out_valid), '0);
    check("R6 in_ready after reset", DATA_W'(in_ready), 1);

    // No start yet: default code is pass-through, live code 3 ignored (R6, R5)
    step(1'b0, 2'd3, 1'b1, 64'h55667788_11223344, 1'b1);
    step(1'b0, 2'd3, 1'b0, '0, 1'b1);

    // Each code with a start in the same cycle as the first word
    for (int m = 0; m < 4; m++) begin
      step(1'b1, 2'(m), 1'b1, 64'h8899aabb_11223344, 1'b1);
      step(1'b0, 2'(m), 1'b1, 64'hccddeeff_01020304, 1'b1);
      step(1'b0, 2'(m), 1'b0, '0, 1'b1);
    end

    // Code changes mid-transfer without start (R5)
    step(1'b1, 2'd1, 1'b1, rnd_beat(), 1'b1);
    step(1'b0, 2'd2, 1'b1, 64'hdeadbeef_a1b2c3d4, 1'b1);
    step(1'b0, 2'd3, 1'b1, rnd_beat(), 1'b1);
    step(1'b0, 2'd0, 1'b0, '0, 1'b1);

    // Stall: hold out_ready low over several cycles (R9)
    step(1'b1, 2'd3, 1'b1, 64'h0f1e2d3c_4b5a6978, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 2'd3, 1'b1, rnd_beat(), 1'b0);
    step(1'b0, 2'd3, 1'b1, rnd_beat(), 1'b1);
    step(1'b0, 2'd3, 1'b0, '0, 1'b1);

    // Random traffic with occasional starts
    for (int i = 0; i < 400; i++)
      step(($urandom() % 16) == 0, 2'($urandom()), 1'($urandom()), rnd_beat(), 1'($urandom()));
    for (int i = 0; i < 3; i++) step(1'b0, 2'd0, 1'b0, '0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule